// File: doc/BRIEF.md
# Parallel-prefix tree adder

A purely combinational N-bit binary adder, with N a power of two. It forms its carries in a recursive prefix network. Each bit first produces a local generate, A AND B, and a local propagate, A XOR B. Prefix cells then merge these pairs over ever wider spans until every bit position holds the group generate of all bits below it. The carry-in is folded into the generate of bit 0, which makes it act as the generate of a virtual bit below the word. Each sum bit is its local propagate XOR the group generate of the bits beneath it. The carry-out is the group generate of the whole word. The carry depth therefore grows with log2 N rather than with N.

A parameter picks one of three prefix topologies. All three come from the same generate-built network, and each takes a different point on the trade-off between logic levels, fanout and wiring tracks:

- Code 0, the fanout tree. It has log2 N levels. At each level the top node of the lower half of a block drives the whole upper half, so fanout is high but there is only one track between levels.
- Code 1, the full-span tree. It has log2 N levels and a fanout of 2. Every bit combines at each level, which needs many parallel tracks.
- Code 2, the sparse tree. It has 2·log2 N − 1 levels. An up-sweep over strides of 2^k is followed by a down-sweep that fills in the missing prefixes, so there are few cells, low fanout and one track.

Any other topology code fails elaboration, and so does an N that is not a power of two. The number of prefix levels is exported as a constant so that integration checks can read it.

Top module: `prefix_tree_adder`

## Requirements
- R1: With TOPO = 0, {cout_o, sum_o} equals a_i + b_i + cin_i taken modulo 2^(N+1), for every input combination.
- R2: With TOPO = 1, {cout_o, sum_o} equals a_i + b_i + cin_i taken modulo 2^(N+1), for every input combination.
- R3: With TOPO = 2, {cout_o, sum_o} equals a_i + b_i + cin_i taken modulo 2^(N+1), for every input combination.
- R4: When every bit position propagates (a_i XOR b_i is all ones), cout_o equals cin_i and every sum_o bit equals NOT cin_i, for every topology.
- R5: A generate at bit 0 (a_i[0] = b_i[0] = 1) with every higher bit propagating and cin_i = 0 yields sum_o = 0 and cout_o = 1, for every topology.
- R6: levels_o reads log2 N for TOPO = 0 and TOPO = 1, and 2·log2 N − 1 for TOPO = 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | N | First addend |
| b_i | input | N | Second addend |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | N | Sum bits |
| cout_o | output | 1 | Carry out of bit N−1 |
| levels_o | output | LVL_W | Constant number of prefix levels in the chosen topology |

## Verification
The case of interest is the one where the carry-in and a word-wide propagate chain meet in the same evaluation. The effect of cin_i then has to cross every prefix level and reach both the top sum bit and cout_o. At the same time the local generate of bit 0 is competing for the same group terms.

This is provoked with operand pairs whose XOR is all ones, with cin_i at both values, and with a bit-0 generate under an all-propagate upper word. Each case runs on all three topologies at 8 and 32 bits. A result is judged against the plain integer sum: the carry-out must equal cin_i, or must be set, and every sum bit must flip together.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
  localparam int TOPO_FANOUT = 0;
  localparam int TOPO_FULLSPAN = 1;
  localparam int TOPO_SPARSE = 2;

  function automatic int pfx_levels(input int topo, input int lg);
    return (topo == TOPO_SPARSE) ? (2 * lg - 1) : lg;
  endfunction

  // Lower-span partner of bit i at level lv, or -1 when the bit passes through.
  function automatic int pfx_partner(input int topo, input int lg, input int lv, input int i);
    int d;
    pfx_partner = -1;
    if (topo == TOPO_FANOUT) begin
      if (((i >> lv) & 1) == 1)
        pfx_partner = ((i >> (lv + 1)) << (lv + 1)) + (1 << lv) - 1;
    end else if (topo == TOPO_FULLSPAN) begin
      if (i >= (1 << lv))
        pfx_partner = i - (1 << lv);
    end else begin
      if (lv < lg) begin
        if (((i + 1) % (1 << (lv + 1))) == 0)
          pfx_partner = i - (1 << lv);
      end else begin
        d = 2 * lg - 2 - lv;
        if ((i >= (1 << (d + 1))) && (((i + 1) % (1 << (d + 1))) == (1 << d)))
          pfx_partner = i - (1 << d);
      end
    end
  endfunction
endpackage

// File: rtl/pfx_pg_gen.sv
module pfx_pg_gen #(
  parameter int N = 32
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic         cin_i,
  output logic [N-1:0] g_o,
  output logic [N-1:0] p_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign p_o[i] = a_i[i] ^ b_i[i];
    if (i == 0) begin : g_fold
      // carry-in treated as generate of the bit below bit 0
      assign g_o[i] = (a_i[i] & b_i[i]) | ((a_i[i] ^ b_i[i]) & cin_i);
    end else begin : g_plain
      assign g_o[i] = a_i[i] & b_i[i];
    end
  end
endmodule

// File: rtl/pfx_cell.sv
module pfx_cell (
  input  logic g_hi_i,
  input  logic p_hi_i,
  input  logic g_lo_i,
  input  logic p_lo_i,
  output logic g_o,
  output logic p_o
);
  assign g_o = g_hi_i | (p_hi_i & g_lo_i);
  assign p_o = p_hi_i & p_lo_i;
endmodule

// File: rtl/pfx_network.sv
module pfx_network #(
  parameter int N    = 32,
  parameter int TOPO = 0
) (
  input  logic [N-1:0] g_i,
  input  logic [N-1:0] p_i,
  output logic [N-1:0] gpre_o,
  output logic [N-1:0] ppre_o
);
  import pfx_pkg::*;

  localparam int LG = $clog2(N);
  localparam int NL = pfx_levels(TOPO, LG);

  logic [N-1:0] g_lv [NL+1];
  logic [N-1:0] p_lv [NL+1];

  assign g_lv[0] = g_i;
  assign p_lv[0] = p_i;

  for (genvar lv = 0; lv < NL; lv++) begin : g_lvl
    for (genvar i = 0; i < N; i++) begin : g_node
      localparam int J = pfx_partner(TOPO, LG, lv, i);
      if (J >= 0) begin : g_black
        pfx_cell u_cell (
          .g_hi_i(g_lv[lv][i]),
          .p_hi_i(p_lv[lv][i]),
          .g_lo_i(g_lv[lv][J]),
          .p_lo_i(p_lv[lv][J]),
          .g_o   (g_lv[lv+1][i]),
          .p_o   (p_lv[lv+1][i])
        );
      end else begin : g_wire
        assign g_lv[lv+1][i] = g_lv[lv][i];
        assign p_lv[lv+1][i] = p_lv[lv][i];
      end
    end
  end

  assign gpre_o = g_lv[NL];
  assign ppre_o = p_lv[NL];

  // each final group propagate must span every bit from 0 up to its own position
  always_comb begin
    logic acc;
    acc = 1'b1;
    for (int i = 0; i < N; i++) begin
      acc = acc & p_i[i];
      AST_GROUP_PROP: assert (ppre_o[i] == acc); // R4
    end
  end
endmodule

// File: rtl/pfx_sum.sv
module pfx_sum #(
  parameter int N = 32
) (
  input  logic [N-1:0] p_i,
  input  logic [N-1:0] gpre_i,
  input  logic         cin_i,
  output logic [N-1:0] sum_o,
  output logic         cout_o
);
  logic [N-1:0] carry;

  assign carry  = {gpre_i[N-2:0], cin_i};
  assign sum_o  = p_i ^ carry;
  assign cout_o = gpre_i[N-1];
endmodule

// File: rtl/prefix_tree_adder.sv
module prefix_tree_adder #(
  parameter int N     = 32,
  parameter int TOPO  = 0,
  parameter int LVL_W = 8
) (
  input  logic [N-1:0]     a_i,
  input  logic [N-1:0]     b_i,
  input  logic             cin_i,
  output logic [N-1:0]     sum_o,
  output logic             cout_o,
  output logic [LVL_W-1:0] levels_o
);
  import pfx_pkg::*;

  localparam int LG = $clog2(N);
  localparam int NL = pfx_levels(TOPO, LG);

  if ((N < 2) || ((1 << LG) != N)) begin : g_bad_width
    $error("prefix_tree_adder: N must be a power of two of at least 2");
  end
  if ((TOPO < TOPO_FANOUT) || (TOPO > TOPO_SPARSE)) begin : g_bad_topo
    $error("prefix_tree_adder: unsupported topology code");
  end

  logic [N-1:0] g_bit, p_bit, gpre, ppre;

  pfx_pg_gen #(.N(N)) u_pg (
    .a_i  (a_i),
    .b_i  (b_i),
    .cin_i(cin_i),
    .g_o  (g_bit),
    .p_o  (p_bit)
  );

  pfx_network #(.N(N), .TOPO(TOPO)) u_net (
    .g_i   (g_bit),
    .p_i   (p_bit),
    .gpre_o(gpre),
    .ppre_o(ppre)
  );

  pfx_sum #(.N(N)) u_sum (
    .p_i   (p_bit),
    .gpre_i(gpre),
    .cin_i (cin_i),
    .sum_o (sum_o),
    .cout_o(cout_o)
  );

  assign levels_o = LVL_W'(NL);

  always_comb begin
    logic [N:0] ref_sum;
    logic [N:0] msk;
    logic [N:0] part;
    ref_sum = {1'b0, a_i} + {1'b0, b_i} + {{N{1'b0}}, cin_i};
    AST_SUM_REF: assert ({cout_o, sum_o} == ref_sum); // R1 R2 R3
    if (&ppre) begin
      AST_CHAIN_HOLD: assert ((cout_o == cin_i) && (sum_o == {N{~cin_i}})); // R4
    end
    for (int i = 0; i < N; i++) begin
      msk  = {(N+1){1'b1}} >> (N - i);
      part = ({1'b0, a_i} & msk) + ({1'b0, b_i} & msk) + {{N{1'b0}}, cin_i};
      AST_CARRY_REF: assert (gpre[i] == part[i+1]); // R5
    end
  end
endmodule

// File: tb/test_prefix_tree_adder.sv
module test_prefix_tree_adder;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic [7:0]  a8 = '0, b8 = '0;
  logic        c8 = 1'b0;
  logic [31:0] a32 = '0, b32 = '0;
  logic        c32 = 1'b0;

  logic [7:0]  s8  [3];
  logic        co8 [3];
  logic [7:0]  lv8 [3];
  logic [31:0] s32 [3];
  logic        co32[3];
  logic [7:0]  lv32[3];

  for (genvar t = 0; t < 3; t++) begin : g8
    prefix_tree_adder #(.N(8), .TOPO(t)) i_prefix_tree_adder (
      .a_i(a8), .b_i(b8), .cin_i(c8),
      .sum_o(s8[t]), .cout_o(co8[t]), .levels_o(lv8[t]));
  end
  for (genvar t = 0; t < 3; t++) begin : g32
    prefix_tree_adder #(.N(32), .TOPO(t)) i_prefix_tree_adder (
      .a_i(a32), .b_i(b32), .cin_i(c32),
      .sum_o(s32[t]), .cout_o(co32[t]), .levels_o(lv32[t]));
  end

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  string rq[3] = '{"R1", "R2", "R3"};

  // {a, b, cin, cout, sum}
  localparam logic [97:0] VEC [8] = '{
    {32'hFFFFFFFF, 32'h00000000, 1'b1, 1'b1, 32'h00000000},
    {32'hFFFFFFFF, 32'h00000001, 1'b0, 1'b1, 32'h00000000},
    {32'hAAAAAAAA, 32'h55555555, 1'b0, 1'b0, 32'hFFFFFFFF},
    {32'hAAAAAAAA, 32'h55555555, 1'b1, 1'b1, 32'h00000000},
    {32'h80000000, 32'h80000000, 1'b0, 1'b1, 32'h00000000},
    {32'h12345678, 32'h87654321, 1'b0, 1'b0, 32'h99999999},
    {32'h00000000, 32'h00000000, 1'b0, 1'b0, 32'h00000000},
    {32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, 1'b1, 32'hFFFFFFFF}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic drive8(input logic [7:0] a, input logic [7:0] b, input logic c);
    a8 = a; b8 = b; c8 = c; #1;
  endtask

  task automatic drive32(input logic [31:0] a, input logic [31:0] b, input logic c);
    a32 = a; b32 = b; c32 = c; #1;
  endtask

  initial begin
    #11;
    // reset state: zero operands give zero results
    for (int t = 0; t < 3; t++) begin
      chk(rq[t], 64'({co8[t], s8[t]}), 64'd0);
      chk(rq[t], 64'({co32[t], s32[t]}), 64'd0);
    end
    #9 rst_ni = 1'b1;

    // R6 level counts
    for (int t = 0; t < 3; t++) begin
      chk("R6", 64'(lv8[t]), (t == 2) ? 64'd5 : 64'd3);
      chk("R6", 64'(lv32[t]), (t == 2) ? 64'd9 : 64'd5);
    end

    // table of 32-bit vectors
    for (int v = 0; v < 8; v++) begin
      drive32(VEC[v][97:66], VEC[v][65:34], VEC[v][33]);
      for (int t = 0; t < 3; t++)
        chk(rq[t], 64'({co32[t], s32[t]}), 64'(VEC[v][32:0]));
      #1;
    end

    // R4 all-propagate chain, both carry-in values
    for (int c = 0; c < 2; c++) begin
      drive8(8'hFF, 8'h00, c[0]);
      for (int t = 0; t < 3; t++)
        chk("R4", 64'({co8[t], s8[t]}), 64'({c[0], {8{~c[0]}}}));
      #1;
      drive8(8'h5A, 8'hA5, c[0]);
      for (int t = 0; t < 3; t++)
        chk("R4", 64'({co8[t], s8[t]}), 64'({c[0], {8{~c[0]}}}));
      #1;
      drive32(32'h0F0F33CC, 32'hF0F0CC33, c[0]);
      for (int t = 0; t < 3; t++)
        chk("R4", 64'({co32[t], s32[t]}), 64'({c[0], {32{~c[0]}}}));
      #1;
    end

    // R5 bit-0 generate ripples to the top
    drive8(8'hFF, 8'h01, 1'b0);
    for (int t = 0; t < 3; t++) chk("R5", 64'({co8[t], s8[t]}), 64'h100);
    #1;
    drive32(32'h00000001, 32'hFFFFFFFF, 1'b0);
    for (int t = 0; t < 3; t++) chk("R5", 64'({co32[t], s32[t]}), 64'h1_0000_0000);
    #1;

    // exhaustive 8-bit
    for (int x = 0; x < 256; x++)
      for (int y = 0; y < 256; y++)
        for (int c = 0; c < 2; c++) begin
          drive8(x[7:0], y[7:0], c[0]);
          for (int t = 0; t < 3; t++)
            chk(rq[t], 64'({co8[t], s8[t]}), 64'(x + y + c));
          #1;
        end

    // random 32-bit
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] ra, rb;
      logic rc;
      logic [32:0] e;
      ra = $urandom; rb = $urandom; rc = $urandom;
      e = {1'b0, ra} + {1'b0, rb} + {32'd0, rc};
      drive32(ra, rb, rc);
      for (int t = 0; t < 3; t++)
        chk(rq[t], 64'({co32[t], s32[t]}), 64'(e));
      #1;
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule